// File: doc/BRIEF.md
# Predicated Set-First Mask Generator

This block turns a source bit mask into a destination mask shaped around the lowest set source bit among the active positions. A 2-bit mode selects one of three output shapes. Set-before-first marks every active position below that bit. Set-including-first also marks the bit itself. Set-only-first marks just that bit. The scan runs from bit 0 upward.

A predicate input can be enabled to say which positions are active. Inactive positions take no part in the search, so a set source bit there never stops the scan. Their destination bits are always written 0. When the predicate is disabled, every position is active.

The unit is purely combinational. An execution pipeline places it between its operand read and its writeback. Register storage and instruction decode belong to the surrounding datapath.

Top module: `setfirst_mask_unit`

## Requirements
- R1: With mode 2'b00 (before-first), each active position strictly below the lowest active set source bit is written 1. That position and every active position above it are written 0.
- R2: With mode 2'b01 (including-first), each active position at or below the lowest active set source bit is written 1. Every active position above it is written 0.
- R3: With mode 2'b10 (only-first), exactly the position of the lowest active set source bit is written 1, and every other position is 0.
- R4: If no active source bit is set, modes 2'b00 and 2'b01 write 1 to every active position, and mode 2'b10 writes all zeros. For example, source 0x00 with no predicate gives 0xFF in mode 2'b00.
- R5: With the predicate enabled, a position is active when its bit in pred_mask is 1. A set source bit at an inactive position has no effect on the search.
- R6: Every inactive position of dst_mask is 0 in every mode.
- R7: With pred_en low, every position is active and the value of pred_mask has no effect on dst_mask.
- R8: Mode 2'b11 is reserved and drives dst_mask to all zeros.
- R9: dst_mask is a combinational function of the current inputs and needs no clock cycle to settle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_mask | input | WIDTH | Source mask that is scanned from bit 0 upward |
| pred_mask | input | WIDTH | Active-position predicate, used when pred_en is high |
| pred_en | input | 1 | 1 = apply pred_mask, 0 = every position active |
| mode | input | 2 | 00 before-first, 01 including-first, 10 only-first, 11 reserved |
| dst_mask | output | WIDTH | Shaped destination mask |

## Verification
Every result is due in the same cycle as its stimulus, with zero register stages between the inputs and dst_mask. The bench changes the inputs just after a rising clock edge. It compares dst_mask at the following falling edge, half a period later, so the logic has settled and no comparison races the edge that applied the inputs. The expected masks come from a bench function that locates the first active set bit by index and then builds each shape position by position.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  typedef enum logic [1:0] {
    SFM_BEFORE  = 2'b00,
    SFM_INCLUDE = 2'b01,
    SFM_ONLY    = 2'b10,
    SFM_RSVD    = 2'b11
  } sfm_mode_e;

  localparam int unsigned SFM_MODE_W = 2;

endpackage

// File: rtl/sfm_active_gate.sv
module sfm_active_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] src_mask,
  input  logic [WIDTH-1:0] pred_mask,
  input  logic             pred_en,
  output logic [WIDTH-1:0] active_mask,
  output logic [WIDTH-1:0] active_src
);

  // Active when predication is off or the predicate bit is set.
  function automatic logic lane_active(input logic en, input logic pbit);
    return !en || pbit;
  endfunction

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign active_mask[i] = lane_active(pred_en, pred_mask[i]);
    assign active_src[i]  = src_mask[i] & active_mask[i];
  end

endmodule

// File: rtl/sfm_first_scan.sv
module sfm_first_scan #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] active_src,
  output logic [WIDTH-1:0] first_hot,
  output logic [WIDTH-1:0] clear_upto,
  output logic [WIDTH-1:0] clear_below,
  output logic             found_any
);

  localparam int unsigned CHAIN = WIDTH + 1;

  // seen[i] is high when some active source bit below position i is set.
  logic [CHAIN-1:0] seen;

  function automatic logic carry_seen(input logic prev, input logic bitv);
    return prev | bitv;
  endfunction

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_scan
    assign seen[i+1]      = carry_seen(seen[i], active_src[i]);
    assign first_hot[i]   = active_src[i] & ~seen[i];
    // No set bit strictly below i.
    assign clear_below[i] = ~seen[i];
    // No set bit at or below i.
    assign clear_upto[i]  = ~seen[i+1];
  end

  assign found_any = seen[WIDTH];

endmodule

// File: rtl/sfm_shape.sv
module sfm_shape
  import sfm_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [SFM_MODE_W-1:0] mode,
  input  logic [WIDTH-1:0]      active_mask,
  input  logic [WIDTH-1:0]      first_hot,
  input  logic [WIDTH-1:0]      clear_upto,
  input  logic [WIDTH-1:0]      clear_below,
  output logic [WIDTH-1:0]      dst_mask
);

  sfm_mode_e mode_e;
  assign mode_e = sfm_mode_e'(mode);

  always_comb begin
    unique case (mode_e)
      SFM_BEFORE:  dst_mask = active_mask & clear_upto;
      SFM_INCLUDE: dst_mask = active_mask & clear_below;
      SFM_ONLY:    dst_mask = first_hot;
      default:     dst_mask = '0;
    endcase
  end

endmodule

// File: rtl/setfirst_mask_unit.sv
module setfirst_mask_unit
  import sfm_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] src_mask,
  input  logic [WIDTH-1:0] pred_mask,
  input  logic             pred_en,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] dst_mask
);

  // Named internal events, observed by the bound checker.
  logic [WIDTH-1:0] active_mask;
  logic [WIDTH-1:0] active_src;
  logic [WIDTH-1:0] first_hot;
  logic [WIDTH-1:0] clear_upto;
  logic [WIDTH-1:0] clear_below;
  logic             found_any;

  sfm_active_gate #(.WIDTH(WIDTH)) u_gate (
    .src_mask    (src_mask),
    .pred_mask   (pred_mask),
    .pred_en     (pred_en),
    .active_mask (active_mask),
    .active_src  (active_src)
  );

  sfm_first_scan #(.WIDTH(WIDTH)) u_scan (
    .active_src  (active_src),
    .first_hot   (first_hot),
    .clear_upto  (clear_upto),
    .clear_below (clear_below),
    .found_any   (found_any)
  );

  sfm_shape #(.WIDTH(WIDTH)) u_shape (
    .mode        (mode),
    .active_mask (active_mask),
    .first_hot   (first_hot),
    .clear_upto  (clear_upto),
    .clear_below (clear_below),
    .dst_mask    (dst_mask)
  );

endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] src_mask,
  input logic [WIDTH-1:0] pred_mask,
  input logic             pred_en,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] dst_mask,
  input logic [WIDTH-1:0] first_hot,
  input logic             found_any
);

  logic [WIDTH-1:0] act;
  assign act = pred_en ? pred_mask : {WIDTH{1'b1}};

  always_comb begin
    // R3: the scanner reports at most one first position
    p_first_single_r3: assert ($onehot0(first_hot));
    // R5: the first position is a set source bit at an active position
    p_first_active_r5: assert ((first_hot & ~(src_mask & act)) == '0);
    // R6: inactive positions stay clear
    p_inactive_zero_r6: assert ((dst_mask & ~act) == '0);
    // R1: before-first never marks the first position
    p_before_excl_r1: assert (!(mode == 2'b00) || ((dst_mask & first_hot) == '0));
    // R2: including-first always marks the first position
    p_incl_first_r2: assert (!(mode == 2'b01) || ((dst_mask & first_hot) == first_hot));
    // R3: only-first has at most one bit set
    p_only_onehot_r3: assert (!(mode == 2'b10) || $onehot0(dst_mask));
    // R4: nothing found fills active positions in the two prefix modes
    p_none_fill_r4: assert (found_any || mode[1] || (dst_mask == act));
    // R4: nothing found leaves only-first empty
    p_none_only_r4: assert (found_any || !(mode == 2'b10) || (dst_mask == '0));
    // R8: reserved mode writes nothing
    p_rsvd_zero_r8: assert (!(mode == 2'b11) || (dst_mask == '0));
  end

endmodule

bind setfirst_mask_unit sfm_checker #(.WIDTH(WIDTH)) u_sfm_chk (
  .src_mask  (src_mask),
  .pred_mask (pred_mask),
  .pred_en   (pred_en),
  .mode      (mode),
  .dst_mask  (dst_mask),
  .first_hot (first_hot),
  .found_any (found_any)
);

// File: tb/setfirst_mask_unit_bench.sv
`timescale 1ns/1ps
module setfirst_mask_unit_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src_mask = '0;
  logic [W-1:0] pred_mask = '0;
  logic         pred_en = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [W-1:0] dst_mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  setfirst_mask_unit #(.WIDTH(W)) u_setfirst_mask_unit (
    .src_mask  (src_mask),
    .pred_mask (pred_mask),
    .pred_en   (pred_en),
    .mode      (mode),
    .dst_mask  (dst_mask)
  );

  // Reference: locate the first active set bit by index, then build the shape.
  function automatic logic [W-1:0] ref_mask(input logic [W-1:0] s, input logic [W-1:0] p,
                                            input logic en, input logic [1:0] m);
    logic [W-1:0] act;
    logic [W-1:0] r;
    int idx;
    act = en ? p : '1;
    idx = -1;
    for (int i = 0; i < W; i++)
      if (idx < 0 && act[i] && s[i]) idx = i;
    r = '0;
    for (int i = 0; i < W; i++) begin
      if (act[i]) begin
        case (m)
          2'b00: r[i] = (idx < 0) || (i < idx);
          2'b01: r[i] = (idx < 0) || (i <= idx);
          2'b10: r[i] = (i == idx);
          default: r[i] = 1'b0;
        endcase
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (src %b pred %b en %b mode %b)",
               tag, got, exp, src_mask, pred_mask, pred_en, mode);
    end
  endtask

  // Drive just after a rising edge; the output is due in the same cycle,
  // so it is compared at the next falling edge.
  task automatic apply(input string tag, input logic [W-1:0] s, input logic [W-1:0] p,
                       input logic en, input logic [1:0] m, input logic [W-1:0] exp);
    @(posedge clk);
    #0.5;
    src_mask = s; pred_mask = p; pred_en = en; mode = m;
    @(negedge clk);
    check(tag, dst_mask, exp);
  endtask

  task automatic apply_ref(input string tag, input logic [W-1:0] s, input logic [W-1:0] p,
                           input logic en, input logic [1:0] m);
    apply(tag, s, p, en, m, ref_mask(s, p, en, m));
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete (got hang, expected finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs: zero source, no predicate, before-first
    @(negedge clk);
    check("R4 idle", dst_mask, 8'hFF);

    // R9: result visible shortly after the inputs change, within one cycle
    @(posedge clk); #0.5;
    src_mask = 8'b0001_0000; pred_en = 1'b0; mode = 2'b10;
    #1;
    check("R9 same-cycle", dst_mask, 8'b0001_0000);

    apply("R1 before",    8'b1001_0100, 8'h00, 1'b0, 2'b00, 8'b0000_0011);
    apply("R2 including", 8'b1001_0100, 8'h00, 1'b0, 2'b01, 8'b0000_0111);
    apply("R3 only",      8'b1001_0100, 8'h00, 1'b0, 2'b10, 8'b0000_0100);
    apply("R1 bit0",      8'b1001_0101, 8'h00, 1'b0, 2'b00, 8'h00);
    apply("R2 bit0",      8'b1001_0101, 8'h00, 1'b0, 2'b01, 8'h01);
    apply("R3 bit0",      8'b1001_0101, 8'h00, 1'b0, 2'b10, 8'h01);
    apply("R2 top bit",   8'b1000_0000, 8'h00, 1'b0, 2'b01, 8'hFF);
    apply("R4 before",    8'h00, 8'h00, 1'b0, 2'b00, 8'hFF);
    apply("R4 including", 8'h00, 8'h00, 1'b0, 2'b01, 8'hFF);
    apply("R4 only",      8'h00, 8'h00, 1'b0, 2'b10, 8'h00);

    // Predicated examples: active positions 7,6,1,0
    apply("R5 before",    8'b1001_0100, 8'b1100_0011, 1'b1, 2'b00, 8'b0100_0011);
    apply("R5 including", 8'b1001_0100, 8'b1100_0011, 1'b1, 2'b01, 8'b1100_0011);
    apply("R5 only",      8'b1101_0100, 8'b1100_0011, 1'b1, 2'b10, 8'b0100_0000);
    // R5/R4: set bits only at inactive positions do not end the search
    apply("R5 ignored",   8'b0011_1100, 8'b1100_0011, 1'b1, 2'b01, 8'b1100_0011);
    apply("R4 only pred", 8'b0011_1100, 8'b1100_0011, 1'b1, 2'b10, 8'h00);
    // R6: inactive positions zero, all-zero predicate clears everything
    apply("R6 empty pred", 8'h00, 8'h00, 1'b1, 2'b00, 8'h00);
    apply("R6 sparse",    8'h00, 8'b1010_1010, 1'b1, 2'b01, 8'b1010_1010);
    // R7: predicate value ignored when disabled
    apply("R7 pred off",  8'b1001_0100, 8'b0000_0100, 1'b0, 2'b00, 8'b0000_0011);
    apply("R7 pred off2", 8'b0000_1000, 8'h00, 1'b0, 2'b01, 8'b0000_1111);
    // R8: reserved mode
    apply("R8 reserved",  8'h00, 8'hFF, 1'b0, 2'b11, 8'h00);
    apply("R8 reserved2", 8'b0110_0000, 8'hFF, 1'b1, 2'b11, 8'h00);

    // Constrained random: sparse sources make long scans likely
    for (int k = 0; k < 1500; k++) begin
      logic [W-1:0] s;
      logic [W-1:0] p;
      logic         en;
      logic [1:0]   m;
      s  = W'($urandom) & W'($urandom);
      p  = W'($urandom);
      en = 1'($urandom);
      m  = 2'($urandom);
      case (m)
        2'b00:   apply_ref("R1 random", s, p, en, m);
        2'b01:   apply_ref("R2 random", s, p, en, m);
        2'b10:   apply_ref("R3 random", s, p, en, m);
        default: apply_ref("R8 random", s, p, en, m);
      endcase
      // R6 at the ports: nothing outside the active set
      if (en) check("R6 random", dst_mask & ~p, '0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule